// File: doc/BRIEF.md
# Split Access Completion Tracker

This block follows one load access from the moment it is handed over until all of its data has come back from the data cache. An access is either whole, and goes to the cache as a single request, or split, and goes as a low part followed by a high part. The block sends the parts in that order. It keeps a small counter of responses still owed and copies each returned part into a result buffer at the right byte offset. When the last owed response arrives it raises a one-cycle done pulse with the assembled bytes.

The cache may turn a request away. If it refuses the first part, the access is abandoned and a retry pulse tells the surrounding queue to try again later. If it refuses only the high part, the block writes off that response, raises the retry pulse, waits for the low part already in flight, and then goes idle without a done pulse. Requests go out only while cache ports remain in the current cycle. The block also keeps a record of the oldest load that met a blocked or refusing cache, so the pipeline can squash and restart from it.

Top module: `split_access_tracker`

## Requirements
- R1: When an access is accepted in the idle state, the count of owed responses is set to 2 for a split access and 1 for a whole one, and `busy` stays high until that count has been brought to zero by responses and write-offs.
- R2: `doneOut` is high for exactly one cycle, in the cycle after the final owed response is presented, and `busy` is low in that same cycle.
- R3: In the result buffer, byte k of a low-part response (`cacheRespHigh`=0) lands at byte k, and byte k of a high-part response (`cacheRespHigh`=1) lands at byte (low size + k). Byte n of `doneData` is bits [8n+7:8n]. Response bytes beyond the part's size are ignored, and unwritten buffer bytes read as zero.
- R4: The low part is requested first, with `cacheReqHigh`=0, the low address and the low size. For a split access the high part is requested next, with `cacheReqHigh`=1, the high address and the high size.
- R5: If the cache refuses the first request (`cacheReqValid` high, `cacheReqReady` low), the access is dropped: `busy` is low and `retryOut` is high in the next cycle, and no done pulse follows.
- R6: If the low part of a split access is accepted and the high part is refused, `retryOut` is high in the next cycle and one owed response is written off. The block stays busy until the low response arrives, then goes idle with no done pulse.
- R7: No request is raised while `extPortUse` equals `NUM_PORTS`. In a cycle with a request, `portsUsed` equals `extPortUse`+1; otherwise it equals `extPortUse`.
- R8: If `cacheBlocked` is high when the first request is due, no request is raised, the access is dropped without a retry pulse, and the access is offered to the blocked-load record.
- R9: A refusal or a blocked cache offers the access's sequence number to the blocked-load record. The record takes the offered number when it is empty or when the offered number is not larger than the held one, and clears `blockedHandled` when it does so. `blockedHandledSet` sets `blockedHandled` while the record is valid, and `blockedClear` empties the record.
- R10: A response presented while no access is in flight leaves the result buffer and `doneOut` unchanged.
- R11: After reset, `busy`, `doneOut`, `retryOut`, `cacheReqValid` and `blockedValid` are low and `doneData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start an access (taken only when idle) |
| reqSplit | input | 1 | 1 = access goes as two parts |
| reqAddrLow | input | ADDR_W | Address of the low (or only) part |
| reqAddrHigh | input | ADDR_W | Address of the high part |
| reqLowSize | input | SIZE_W | Byte count of the low (or only) part |
| reqHighSize | input | SIZE_W | Byte count of the high part |
| reqSeq | input | SEQ_W | Age tag of the load, smaller is older |
| cacheBlocked | input | 1 | Cache cannot take requests this cycle |
| extPortUse | input | PORT_W | Cache ports already used by others this cycle |
| cacheReqValid | output | 1 | Request to the cache |
| cacheReqReady | input | 1 | Cache accepts the request in the same cycle |
| cacheReqAddr | output | ADDR_W | Request address |
| cacheReqSize | output | SIZE_W | Request byte count |
| cacheReqHigh | output | 1 | 1 = request carries the high part |
| cacheRespValid | input | 1 | Response from the cache |
| cacheRespHigh | input | 1 | 1 = response is for the high part |
| cacheRespData | input | 8*DATA_BYTES | Response bytes, byte 0 in bits 7:0 |
| portsUsed | output | PORT_W | Ports in use this cycle including this block |
| busy | output | 1 | An access is in flight |
| doneOut | output | 1 | One-cycle completion pulse |
| doneData | output | 8*DATA_BYTES | Assembled result |
| retryOut | output | 1 | One-cycle pulse after a refusal |
| blockedValid | output | 1 | Blocked-load record holds an entry |
| blockedSeq | output | SEQ_W | Age tag of the recorded load |
| blockedHandled | output | 1 | The recorded load has been dealt with |
| blockedClear | input | 1 | Empty the blocked-load record |
| blockedHandledSet | input | 1 | Mark the recorded load as handled |

## Verification
Whole accesses of every size up to the buffer width are mixed with split accesses whose boundary moves from one byte to the last. Response data is filled with random garbage beyond each part's size, so a wrong offset or a missing byte mask shows up in `doneData`. Split responses come back low-first and high-first, which separates placement by part tag from placement by arrival order. Refusals of the first and of the second part, a blocked cache and zero-port cycles exercise the counter write-off, the dropped-access path and the port gate. Ascending and descending sequence numbers fed to the blocked-load record show whether it keeps the oldest load.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    SAT_IDLE    = 2'd0,
    SAT_SEND_LO = 2'd1,
    SAT_SEND_HI = 2'd2,
    SAT_WAIT    = 2'd3
  } satState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDesc;   // capture descriptor, load count, clear buffer
    logic selHigh;    // request mux points at the high part
    logic respTake;   // a response is absorbed this cycle
    logic refuseDec;  // high part refused: write off one response
  } satStrobe_t;

endpackage

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  parameter int SEQ_W      = 16,
  localparam int SIZE_W    = $clog2(DATA_BYTES + 1),
  localparam int DATA_W    = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  satStrobe_t        strobe,
  input  logic [ADDR_W-1:0] inAddrLow,
  input  logic [ADDR_W-1:0] inAddrHigh,
  input  logic              inSplit,
  input  logic [SIZE_W-1:0] inLowSize,
  input  logic [SIZE_W-1:0] inHighSize,
  input  logic [SEQ_W-1:0]  inSeq,
  input  logic              respHigh,
  input  logic [DATA_W-1:0] respData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [SIZE_W-1:0] reqSize,
  output logic              descSplit,
  output logic [SEQ_W-1:0]  descSeq,
  output logic              countNextZero,
  output logic [DATA_W-1:0] bufData
);

  localparam int SUM_W = SIZE_W + 1;

  logic [ADDR_W-1:0] addrLow, addrHigh;
  logic [SIZE_W-1:0] lowSize, highSize;
  logic [1:0]        count, countNext;
  logic [SIZE_W-1:0] placeOff, placeSize;
  logic [DATA_W-1:0] placeData, placeMask;

  assign reqAddr = strobe.selHigh ? addrHigh : addrLow;
  assign reqSize = strobe.selHigh ? highSize : lowSize;

  assign countNext     = count - 2'(strobe.respTake) - 2'(strobe.refuseDec);
  assign countNextZero = (countNext == 2'd0);

  // the high part sits right after the low part's bytes
  assign placeOff  = respHigh ? lowSize : '0;
  assign placeSize = respHigh ? highSize : lowSize;
  assign placeData = respData << {placeOff, 3'b000};

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_mask
    assign placeMask[8*b +: 8] =
      ((SUM_W'(b) >= SUM_W'(placeOff)) &&
       (SUM_W'(b) <  SUM_W'(placeOff) + SUM_W'(placeSize))) ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLow   <= '0;
      addrHigh  <= '0;
      lowSize   <= '0;
      highSize  <= '0;
      descSplit <= 1'b0;
      descSeq   <= '0;
      count     <= 2'd0;
      bufData   <= '0;
    end else if (strobe.loadDesc) begin
      addrLow   <= inAddrLow;
      addrHigh  <= inAddrHigh;
      lowSize   <= inLowSize;
      highSize  <= inHighSize;
      descSplit <= inSplit;
      descSeq   <= inSeq;
      count     <= inSplit ? 2'd2 : 2'd1;
      bufData   <= '0;
    end else begin
      count <= countNext;
      if (strobe.respTake) begin
        bufData <= (bufData & ~placeMask) | (placeData & placeMask);
      end
    end
  end

  a_r1_count_start: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDesc |=> (count == ($past(inSplit) ? 2'd2 : 2'd1)));

  a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (count == 2'd0) |-> !(strobe.respTake || strobe.refuseDec));

  a_r3_buffer_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDesc |=> (bufData == '0));

endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
#(
  parameter int SEQ_W     = 16,
  parameter int NUM_PORTS = 2,
  localparam int PORT_W   = $clog2(NUM_PORTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              cacheBlocked,
  input  logic              cacheReqReady,
  input  logic              cacheRespValid,
  input  logic [PORT_W-1:0] extPortUse,
  input  logic              descSplit,
  input  logic [SEQ_W-1:0]  descSeq,
  input  logic              countNextZero,
  input  logic              blockedClear,
  input  logic              blockedHandledSet,
  output satStrobe_t        strobe,
  output logic              cacheReqValid,
  output logic [PORT_W-1:0] portsUsed,
  output logic              busy,
  output logic              doneOut,
  output logic              retryOut,
  output logic              blockedValid,
  output logic [SEQ_W-1:0]  blockedSeq,
  output logic              blockedHandled
);

  satState_t state, stateNext;
  logic portsFree, reqOut, refused;
  logic blockEvt, retryNext, doneNext, dropSet, dropped;

  assign portsFree = (extPortUse < PORT_W'(NUM_PORTS));
  assign refused   = reqOut && !cacheReqReady;

  // strobes: no dependence on the datapath's count feedback
  always_comb begin
    strobe = '0;
    reqOut = 1'b0;
    unique case (state)
      SAT_IDLE:    strobe.loadDesc = reqValid;
      SAT_SEND_LO: reqOut = portsFree && !cacheBlocked;
      SAT_SEND_HI: begin
        strobe.selHigh   = 1'b1;
        strobe.respTake  = cacheRespValid;
        reqOut           = portsFree;
        strobe.refuseDec = portsFree && !cacheReqReady;
      end
      SAT_WAIT:    strobe.respTake = cacheRespValid;
      default:     ;
    endcase
  end

  always_comb begin
    stateNext = state;
    blockEvt  = 1'b0;
    retryNext = 1'b0;
    doneNext  = 1'b0;
    dropSet   = 1'b0;
    unique case (state)
      SAT_IDLE: if (reqValid) stateNext = SAT_SEND_LO;
      SAT_SEND_LO: begin
        if (cacheBlocked) begin
          blockEvt  = 1'b1;
          stateNext = SAT_IDLE;
        end else if (reqOut) begin
          if (refused) begin
            blockEvt  = 1'b1;
            retryNext = 1'b1;
            stateNext = SAT_IDLE;
          end else begin
            stateNext = descSplit ? SAT_SEND_HI : SAT_WAIT;
          end
        end
      end
      SAT_SEND_HI: begin
        if (refused) begin
          blockEvt  = 1'b1;
          retryNext = 1'b1;
          dropSet   = 1'b1;
          stateNext = countNextZero ? SAT_IDLE : SAT_WAIT;
        end else if (reqOut) begin
          stateNext = SAT_WAIT;
        end
      end
      SAT_WAIT: begin
        if (countNextZero) begin
          stateNext = SAT_IDLE;
          doneNext  = !dropped;
        end
      end
      default: stateNext = SAT_IDLE;
    endcase
  end

  assign cacheReqValid = reqOut;
  assign portsUsed     = extPortUse + PORT_W'(reqOut);
  assign busy          = (state != SAT_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SAT_IDLE;
      doneOut  <= 1'b0;
      retryOut <= 1'b0;
      dropped  <= 1'b0;
    end else begin
      state    <= stateNext;
      doneOut  <= doneNext;
      retryOut <= retryNext;
      if (strobe.loadDesc)  dropped <= 1'b0;
      else if (dropSet)     dropped <= 1'b1;
    end
  end

  // oldest-blocked-load record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockedValid   <= 1'b0;
      blockedSeq     <= '0;
      blockedHandled <= 1'b0;
    end else begin
      if (blockedClear) blockedValid <= 1'b0;
      if (blockedHandledSet && blockedValid) blockedHandled <= 1'b1;
      if (blockEvt && (!blockedValid || blockedClear || (descSeq <= blockedSeq))) begin
        blockedValid   <= 1'b1;
        blockedSeq     <= descSeq;
        blockedHandled <= 1'b0;
      end
    end
  end

  a_r7_port_budget: assert property (@(posedge clk) disable iff (!rstN)
    cacheReqValid |-> (extPortUse < PORT_W'(NUM_PORTS)));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  a_r5_drop_on_first: assert property (@(posedge clk) disable iff (!rstN)
    (cacheReqValid && !cacheReqReady && !strobe.selHigh) |=> (!busy && retryOut));

  a_r5_retry_no_done: assert property (@(posedge clk) disable iff (!rstN)
    retryOut |-> !doneOut);

  a_r9_keep_oldest: assert property (@(posedge clk) disable iff (!rstN)
    (blockedValid && $past(blockedValid) && !$past(blockedClear))
      |-> (blockedSeq <= $past(blockedSeq)));

endmodule

// File: rtl/split_access_tracker.sv
module split_access_tracker
  import sat_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  parameter int SEQ_W      = 16,
  parameter int NUM_PORTS  = 2,
  localparam int SIZE_W    = $clog2(DATA_BYTES + 1),
  localparam int DATA_W    = 8 * DATA_BYTES,
  localparam int PORT_W    = $clog2(NUM_PORTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqSplit,
  input  logic [ADDR_W-1:0] reqAddrLow,
  input  logic [ADDR_W-1:0] reqAddrHigh,
  input  logic [SIZE_W-1:0] reqLowSize,
  input  logic [SIZE_W-1:0] reqHighSize,
  input  logic [SEQ_W-1:0]  reqSeq,
  input  logic              cacheBlocked,
  input  logic [PORT_W-1:0] extPortUse,
  output logic              cacheReqValid,
  input  logic              cacheReqReady,
  output logic [ADDR_W-1:0] cacheReqAddr,
  output logic [SIZE_W-1:0] cacheReqSize,
  output logic              cacheReqHigh,
  input  logic              cacheRespValid,
  input  logic              cacheRespHigh,
  input  logic [DATA_W-1:0] cacheRespData,
  output logic [PORT_W-1:0] portsUsed,
  output logic              busy,
  output logic              doneOut,
  output logic [DATA_W-1:0] doneData,
  output logic              retryOut,
  output logic              blockedValid,
  output logic [SEQ_W-1:0]  blockedSeq,
  output logic              blockedHandled,
  input  logic              blockedClear,
  input  logic              blockedHandledSet
);

  satStrobe_t       strobe;
  logic             descSplit;
  logic [SEQ_W-1:0] descSeq;
  logic             countNextZero;

  assign cacheReqHigh = strobe.selHigh;

  sat_ctrl #(.SEQ_W(SEQ_W), .NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cacheBlocked(cacheBlocked),
    .cacheReqReady(cacheReqReady), .cacheRespValid(cacheRespValid),
    .extPortUse(extPortUse), .descSplit(descSplit), .descSeq(descSeq),
    .countNextZero(countNextZero), .blockedClear(blockedClear),
    .blockedHandledSet(blockedHandledSet), .strobe(strobe),
    .cacheReqValid(cacheReqValid), .portsUsed(portsUsed), .busy(busy),
    .doneOut(doneOut), .retryOut(retryOut), .blockedValid(blockedValid),
    .blockedSeq(blockedSeq), .blockedHandled(blockedHandled)
  );

  sat_datapath #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .SEQ_W(SEQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddrLow(reqAddrLow),
    .inAddrHigh(reqAddrHigh), .inSplit(reqSplit), .inLowSize(reqLowSize),
    .inHighSize(reqHighSize), .inSeq(reqSeq), .respHigh(cacheRespHigh),
    .respData(cacheRespData), .reqAddr(cacheReqAddr), .reqSize(cacheReqSize),
    .descSplit(descSplit), .descSeq(descSeq), .countNextZero(countNextZero),
    .bufData(doneData)
  );

endmodule

// File: tb/sim_split_access_tracker.sv
module sim_split_access_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DB = 8;
  localparam int SQW = 16;
  localparam int NP = 2;
  localparam int SW = $clog2(DB + 1);
  localparam int DW = 8 * DB;
  localparam int PW = $clog2(NP + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqSplit = 0;
  logic [AW-1:0] reqAddrLow = '0, reqAddrHigh = '0;
  logic [SW-1:0] reqLowSize = '0, reqHighSize = '0;
  logic [SQW-1:0] reqSeq = '0;
  logic cacheBlocked = 0, cacheReqReady = 0;
  logic [PW-1:0] extPortUse = '0;
  logic cacheReqValid, cacheReqHigh;
  logic [AW-1:0] cacheReqAddr;
  logic [SW-1:0] cacheReqSize;
  logic cacheRespValid = 0, cacheRespHigh = 0;
  logic [DW-1:0] cacheRespData = '0;
  logic [PW-1:0] portsUsed;
  logic busy, doneOut, retryOut, blockedValid, blockedHandled;
  logic [DW-1:0] doneData;
  logic [SQW-1:0] blockedSeq;
  logic blockedClear = 0, blockedHandledSet = 0;

  int total = 0, bad = 0;
  bit finished = 0;
  // bench model of the blocked-load record
  bit mValid = 0, mHandled = 0;
  logic [SQW-1:0] mSeq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_access_tracker #(.ADDR_W(AW), .DATA_BYTES(DB), .SEQ_W(SQW), .NUM_PORTS(NP)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSplit(reqSplit),
    .reqAddrLow(reqAddrLow), .reqAddrHigh(reqAddrHigh), .reqLowSize(reqLowSize),
    .reqHighSize(reqHighSize), .reqSeq(reqSeq), .cacheBlocked(cacheBlocked),
    .extPortUse(extPortUse), .cacheReqValid(cacheReqValid), .cacheReqReady(cacheReqReady),
    .cacheReqAddr(cacheReqAddr), .cacheReqSize(cacheReqSize), .cacheReqHigh(cacheReqHigh),
    .cacheRespValid(cacheRespValid), .cacheRespHigh(cacheRespHigh),
    .cacheRespData(cacheRespData), .portsUsed(portsUsed), .busy(busy),
    .doneOut(doneOut), .doneData(doneData), .retryOut(retryOut),
    .blockedValid(blockedValid), .blockedSeq(blockedSeq), .blockedHandled(blockedHandled),
    .blockedClear(blockedClear), .blockedHandledSet(blockedHandledSet)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] expData(input bit split, input int lsz, input int hsz,
                                             input logic [DW-1:0] dLo, input logic [DW-1:0] dHi);
    logic [DW-1:0] e = '0;
    for (int b = 0; b < lsz; b++) e[8*b +: 8] = dLo[8*b +: 8];
    if (split) for (int k = 0; k < hsz; k++) e[8*(lsz+k) +: 8] = dHi[8*k +: 8];
    return e;
  endfunction

  function automatic void modelBlock(input logic [SQW-1:0] s);
    if (!mValid || s <= mSeq) begin
      mValid = 1; mSeq = s; mHandled = 0;
    end
  endfunction

  task automatic checkRecord();
    chk("R9 valid", DW'(blockedValid), DW'(mValid));
    if (mValid) begin
      chk("R9 seq", DW'(blockedSeq), DW'(mSeq));
      chk("R9 handled", DW'(blockedHandled), DW'(mHandled));
    end
  endtask

  task automatic respond(input bit hi, input logic [DW-1:0] d);
    cacheRespValid = 1; cacheRespHigh = hi; cacheRespData = d;
    @(negedge clk);
    cacheRespValid = 0; cacheRespData = {2{$urandom()}};
  endtask

  task automatic doAccess(input bit split, input int lsz, input int hsz,
                          input logic [DW-1:0] dLo, input logic [DW-1:0] dHi,
                          input logic [SQW-1:0] seq, input bit blk, input bit refLo,
                          input bit refHi, input bit hiFirst, input int stall);
    logic [AW-1:0] aLo = $urandom();
    logic [AW-1:0] aHi = aLo + AW'(lsz);
    logic [PW-1:0] ex;
    @(negedge clk);
    reqValid = 1; reqSplit = split; reqAddrLow = aLo; reqAddrHigh = aHi;
    reqLowSize = SW'(lsz); reqHighSize = SW'(hsz); reqSeq = seq;
    @(negedge clk);
    reqValid = 0; reqSeq = $urandom();
    chk("R1 busy after start", DW'(busy), 1);
    for (int i = 0; i < stall; i++) begin
      extPortUse = PW'(NP);
      #1 chk("R7 no request without port", DW'(cacheReqValid), 0);
      chk("R7 ports used idle", DW'(portsUsed), DW'(NP));
      @(negedge clk);
    end
    if (blk) begin
      extPortUse = '0; cacheBlocked = 1;
      #1 chk("R8 no request while blocked", DW'(cacheReqValid), 0);
      @(negedge clk);
      cacheBlocked = 0;
      chk("R8 dropped", DW'(busy), 0);
      chk("R8 no retry", DW'(retryOut), 0);
      chk("R8 no done", DW'(doneOut), 0);
      modelBlock(seq); checkRecord();
      return;
    end
    ex = PW'($urandom_range(NP - 1, 0));
    extPortUse = ex; cacheReqReady = !refLo;
    #1 chk("R4 low valid", DW'(cacheReqValid), 1);
    chk("R4 low addr", DW'(cacheReqAddr), DW'(aLo));
    chk("R4 low size", DW'(cacheReqSize), DW'(lsz));
    chk("R4 low tag", DW'(cacheReqHigh), 0);
    chk("R7 ports used", DW'(portsUsed), DW'(ex) + 1);
    @(negedge clk);
    cacheReqReady = 0; extPortUse = '0;
    if (refLo) begin
      chk("R5 retry", DW'(retryOut), 1);
      chk("R5 idle", DW'(busy), 0);
      chk("R5 no done", DW'(doneOut), 0);
      modelBlock(seq); checkRecord();
      return;
    end
    if (split) begin
      for (int i = 0; i < stall; i++) begin
        extPortUse = PW'(NP);
        #1 chk("R7 no high request without port", DW'(cacheReqValid), 0);
        @(negedge clk);
      end
      extPortUse = PW'($urandom_range(NP - 1, 0)); cacheReqReady = !refHi;
      #1 chk("R4 high valid", DW'(cacheReqValid), 1);
      chk("R4 high addr", DW'(cacheReqAddr), DW'(aHi));
      chk("R4 high size", DW'(cacheReqSize), DW'(hsz));
      chk("R4 high tag", DW'(cacheReqHigh), 1);
      @(negedge clk);
      cacheReqReady = 0; extPortUse = '0;
      if (refHi) begin
        chk("R6 retry", DW'(retryOut), 1);
        chk("R6 still busy", DW'(busy), 1);
        modelBlock(seq); checkRecord();
      end
    end
    if (split && !refHi) begin
      respond(hiFirst, hiFirst ? dHi : dLo);
      chk("R1 busy with one owed", DW'(busy), 1);
      chk("R1 no early done", DW'(doneOut), 0);
      respond(!hiFirst, hiFirst ? dLo : dHi);
    end else begin
      respond(1'b0, dLo);
    end
    chk("R1 idle after last", DW'(busy), 0);
    if (refHi) begin
      chk("R6 no done", DW'(doneOut), 0);
    end else begin
      chk("R2 done pulse", DW'(doneOut), 1);
      chk("R3 assembled data", doneData, expData(split, lsz, hsz, dLo, dHi));
    end
    @(negedge clk);
    chk("R2 pulse one cycle", DW'(doneOut), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish();
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", DW'(busy), 0);
    chk("R11 done", DW'(doneOut), 0);
    chk("R11 retry", DW'(retryOut), 0);
    chk("R11 req", DW'(cacheReqValid), 0);
    chk("R11 blocked", DW'(blockedValid), 0);
    chk("R11 data", doneData, '0);
    rstN = 1;

    // directed: whole full width, whole one byte, split boundaries, response orders
    doAccess(0, DB, 0, {2{$urandom()}}, '0, 16'd10, 0, 0, 0, 0, 0);
    doAccess(0, 1, 0, {2{$urandom()}}, '0, 16'd11, 0, 0, 0, 0, 1);
    doAccess(1, 1, DB-1, {2{$urandom()}}, {2{$urandom()}}, 16'd12, 0, 0, 0, 0, 0);
    doAccess(1, DB-1, 1, {2{$urandom()}}, {2{$urandom()}}, 16'd13, 0, 0, 0, 1, 2);
    doAccess(1, 4, 4, {2{$urandom()}}, {2{$urandom()}}, 16'd14, 0, 0, 0, 1, 0);

    // R10: stray response while idle is ignored
    held = doneData;
    respond(1'b1, {2{$urandom()}});
    chk("R10 buffer kept", doneData, held);
    chk("R10 no done", DW'(doneOut), 0);

    // R9 directed: record keeps the oldest load
    doAccess(0, 4, 0, '0, '0, 16'd50, 0, 1, 0, 0, 0);
    doAccess(1, 3, 2, '0, '0, 16'd70, 0, 0, 1, 0, 0);
    chk("R9 older kept", DW'(blockedSeq), 50);
    @(negedge clk); blockedHandledSet = 1;
    @(negedge clk); blockedHandledSet = 0; mHandled = 1;
    chk("R9 handled set", DW'(blockedHandled), 1);
    doAccess(0, 2, 0, '0, '0, 16'd30, 1, 0, 0, 0, 0);
    chk("R9 younger replaced by older", DW'(blockedSeq), 30);
    chk("R9 handled cleared", DW'(blockedHandled), 0);
    @(negedge clk); blockedClear = 1;
    @(negedge clk); blockedClear = 0; mValid = 0;
    chk("R9 cleared", DW'(blockedValid), 0);

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      bit sp = $urandom_range(1, 0);
      int ls = sp ? int'($urandom_range(DB - 1, 1)) : int'($urandom_range(DB, 1));
      int hs = sp ? int'($urandom_range(DB - ls, 1)) : 0;
      bit bk = ($urandom_range(9, 0) == 0);
      bit rl = ($urandom_range(7, 0) == 0);
      bit rh = sp && ($urandom_range(5, 0) == 0);
      doAccess(sp, ls, hs, {2{$urandom()}}, {2{$urandom()}}, SQW'($urandom()),
               bk, rl, rh, $urandom_range(1, 0), $urandom_range(2, 0));
      if (n % 20 == 19) begin
        @(negedge clk); blockedClear = 1;
        @(negedge clk); blockedClear = 0; mValid = 0;
        checkRecord();
      end
    end
    finish();
  end

endmodule